// File: doc/BRIEF.md
# GMII Ethernet Frame Transmitter

This block turns a frame request into a complete Ethernet frame on an 8-bit GMII-style transmit interface, one byte per rising clock edge. A request carries a destination MAC address, a source MAC address and a payload length. The payload bytes are loaded into an internal byte buffer through a simple write port before the request is made. The block then sends the preamble, the start delimiter, a 14-byte header, the buffered payload and a CRC-32 frame check sequence that it computes as the bytes go out.

Once the last check byte has been sent, the transmitter enforces a fixed idle gap and then signals completion with a one-cycle `done` pulse. At that point it is ready for the next request. No frame can start until the configuration-busy input has been observed low, then high, then low again after reset. This keeps the link quiet while the surrounding logic is still setting itself up.

Top module: `gmii_frame_tx`

## Requirements
- R1: While `rst_n` is low, `gmii_txd` is 0, `gmii_tx_en`, `gmii_tx_er`, `ready` and `done` are all 0.
- R2: `ready` stays low, and no request is taken, until `cfg_busy` has been sampled low, then high, then low again after reset. `ready` rises on the edge that samples that final low. Once armed, the block stays armed.
- R3: A request is taken on a rising edge where `ready` and `start` are both high. From the next edge on, the frame begins with seven bytes of 0x55 and then one byte of 0xD5.
- R4: The 14 bytes after 0xD5 are `dst_mac`, then `src_mac`, then a 16-bit field holding the payload byte count, each sent most significant byte first.
- R5: The payload follows the header and consists of buffer addresses 0 to `pay_len`-1 in rising address order. Lengths from PAY_MIN (46) up to PAY_MAX (1500) are supported.
- R6: The frame ends with four check bytes. The CRC register starts at 0xFFFFFFFF and absorbs every header and payload byte, least significant bit first, using the reflected form 0xEDB88320 of the polynomial 0x04C11DB7. The check bytes are the complement of the final register, low byte first.
- R7: `gmii_tx_en` is high and `gmii_tx_er` low for every frame byte. `gmii_tx_en` drops on the edge after the last check byte. While `gmii_tx_en` is low, `gmii_txd` is 0 and `gmii_tx_er` is 0.
- R8: `done` pulses for one cycle, and `ready` rises with it, in the GAP_CYCLES-th cycle (200) with `gmii_tx_en` low. With `start` held high, the next frame's first byte follows after exactly GAP_CYCLES+1 low cycles.
- R9: A `start` asserted during a frame or during the gap is ignored and leaves the frame in flight unchanged.
- R10: A request with `pay_len` below PAY_MIN or above PAY_MAX is ignored. No frame is sent and `ready` stays high.
- R11: Both addresses and the length are captured when the request is taken. Later changes on those inputs do not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, all activity on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_busy | input | 1 | Configuration-busy flag that gates the first frame |
| start | input | 1 | Frame request, taken when `ready` is high |
| dst_mac | input | 48 | Destination address of the requested frame |
| src_mac | input | 48 | Source address of the requested frame |
| pay_len | input | 11 | Payload byte count of the requested frame |
| buf_we | input | 1 | Payload buffer write enable |
| buf_waddr | input | 11 | Payload buffer write address |
| buf_wdata | input | 8 | Payload buffer write data |
| ready | output | 1 | Armed and idle; a request would be taken now |
| done | output | 1 | One-cycle pulse at the end of the idle gap |
| gmii_txd | output | 8 | Transmit byte |
| gmii_tx_en | output | 1 | Transmit byte valid |
| gmii_tx_er | output | 1 | Transmit error, always low |

## Verification
The hardest conditions to reach from the ports are the partial arming states and the exact edge on which the gap ends. The stimulus holds `cfg_busy` high out of reset and raises `start` in each intermediate arming phase, so that early requests must be dropped. To land a request on the first cycle the gap permits, the bench holds `start` high across the `done` pulse. A behavioural model, built from byte queues and a table-driven CRC, predicts every output byte, `ready` and `done` on every clock. Mid-frame requests, address changes made during a frame and out-of-range lengths are all checked against that same model.

// File: rtl/gmii_tx_pkg.sv
package gmii_tx_pkg;

  localparam logic [7:0]  PRE_BYTE       = 8'h55;
  localparam logic [7:0]  SFD_BYTE       = 8'hD5;
  localparam int          PRE_COUNT      = 7;
  localparam int          HDR_COUNT      = 14;
  localparam int          FCS_COUNT      = 4;
  localparam logic [31:0] CRC_POLY_REFL  = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET     = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_HDR,
    ST_PAY,
    ST_FCS,
    ST_GAP
  } tx_state_e;

  typedef enum logic [1:0] {
    AR_SEEK_LO,
    AR_SEEK_HI,
    AR_SEEK_LO2,
    AR_DONE
  } arm_state_e;

  // One byte of reflected CRC-32, least significant data bit first.
  function automatic logic [31:0] crc32_step(input logic [31:0] cin,
                                             input logic [7:0]  din);
    logic [31:0] r;
    r = cin;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ din[b]) r = (r >> 1) ^ CRC_POLY_REFL;
      else               r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/gmii_tx_arm.sv
module gmii_tx_arm
  import gmii_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_busy,
  output logic armed
);

  arm_state_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      AR_SEEK_LO:  if (!cfg_busy) ph_d = AR_SEEK_HI;
      AR_SEEK_HI:  if (cfg_busy)  ph_d = AR_SEEK_LO2;
      AR_SEEK_LO2: if (!cfg_busy) ph_d = AR_DONE;
      AR_DONE:     ph_d = AR_DONE;
      default:     ph_d = AR_SEEK_LO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= AR_SEEK_LO;
    else        ph_q <= ph_d;
  end

  assign armed = (ph_q == AR_DONE);

  // R2: arming is permanent until reset
  p_arm_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  // R2: arming only follows a low sample of the busy flag
  p_arm_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> !$past(cfg_busy));

endmodule

// File: rtl/gmii_tx_crc.sv
module gmii_tx_crc
  import gmii_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [31:0] crc
);

  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init)     crc_d = CRC_PRESET;
    else if (upd) crc_d = crc32_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_PRESET;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

  // R6: register is untouched when neither preset nor update is requested
  p_crc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !upd) |=> $stable(crc_q));

endmodule

// File: rtl/gmii_tx_buf.sv
module gmii_tx_buf #(
  parameter int DEPTH = 1500,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;

endmodule

// File: rtl/gmii_frame_tx.sv
module gmii_frame_tx
  import gmii_tx_pkg::*;
#(
  parameter  int PAY_MIN    = 46,
  parameter  int PAY_MAX    = 1500,
  parameter  int GAP_CYCLES = 200,
  localparam int LW         = $clog2(PAY_MAX + 1),
  localparam int AW         = $clog2(PAY_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_busy,
  input  logic          start,
  input  logic [47:0]   dst_mac,
  input  logic [47:0]   src_mac,
  input  logic [LW-1:0] pay_len,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_waddr,
  input  logic [7:0]    buf_wdata,
  output logic          ready,
  output logic          done,
  output logic [7:0]    gmii_txd,
  output logic          gmii_tx_en,
  output logic          gmii_tx_er
);

  localparam int GW = $clog2(GAP_CYCLES + 1);

  tx_state_e     st_q, st_d;
  logic [LW-1:0] idx_q, idx_d;
  logic [GW-1:0] gap_q, gap_d;
  logic [47:0]   da_q, sa_q;
  logic [LW-1:0] len_q;
  logic [7:0]    txd_q, txd_d;
  logic          en_q, en_d;
  logic          done_q, done_d;

  logic          armed;
  logic          len_ok;
  logic          accept;
  logic          frame_active;
  logic [7:0]    cur_byte;
  logic [7:0]    pay_byte;
  logic [7:0]    hdr_byte;
  logic [7:0]    fcs_byte;
  logic [111:0]  hdr_vec;
  logic [6:0]    hdr_shift;
  logic [31:0]   crc_val;
  logic          crc_upd;

  // ---------------------------------------------------------------
  // Sub-blocks
  // ---------------------------------------------------------------
  gmii_tx_arm u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_busy (cfg_busy),
    .armed    (armed)
  );

  gmii_tx_crc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (accept),
    .upd   (crc_upd),
    .din   (cur_byte),
    .crc   (crc_val)
  );

  gmii_tx_buf #(
    .DEPTH (PAY_MAX),
    .AW    (AW)
  ) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (idx_q[AW-1:0]),
    .rdata (pay_byte)
  );

  // ---------------------------------------------------------------
  // Request qualification
  // ---------------------------------------------------------------
  assign len_ok = (pay_len >= LW'(PAY_MIN)) && (pay_len <= LW'(PAY_MAX));
  assign ready  = armed && (st_q == ST_IDLE);
  assign accept = ready && start && len_ok;

  // ---------------------------------------------------------------
  // Byte selection
  // ---------------------------------------------------------------
  assign hdr_vec   = {da_q, sa_q, 16'(len_q)};
  assign hdr_shift = {4'(4'd13 - idx_q[3:0]), 3'b000};
  assign hdr_byte  = 8'(hdr_vec >> hdr_shift);
  assign fcs_byte  = 8'((~crc_val) >> {idx_q[1:0], 3'b000});

  always_comb begin
    unique case (st_q)
      ST_PRE:  cur_byte = PRE_BYTE;
      ST_SFD:  cur_byte = SFD_BYTE;
      ST_HDR:  cur_byte = hdr_byte;
      ST_PAY:  cur_byte = pay_byte;
      ST_FCS:  cur_byte = fcs_byte;
      default: cur_byte = 8'h00;
    endcase
  end

  assign frame_active = (st_q == ST_PRE) || (st_q == ST_SFD) || (st_q == ST_HDR) ||
                        (st_q == ST_PAY) || (st_q == ST_FCS);
  assign crc_upd      = (st_q == ST_HDR) || (st_q == ST_PAY);

  // ---------------------------------------------------------------
  // Next-state logic
  // ---------------------------------------------------------------
  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    gap_d  = gap_q;
    done_d = 1'b0;
    en_d   = frame_active;
    txd_d  = frame_active ? cur_byte : 8'h00;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d  = ST_PRE;
          idx_d = '0;
        end
      end
      ST_PRE: begin
        if (idx_q == LW'(PRE_COUNT - 1)) begin
          st_d  = ST_SFD;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_SFD: begin
        st_d  = ST_HDR;
        idx_d = '0;
      end
      ST_HDR: begin
        if (idx_q == LW'(HDR_COUNT - 1)) begin
          st_d  = ST_PAY;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_PAY: begin
        if (idx_q == len_q - 1'b1) begin
          st_d  = ST_FCS;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_FCS: begin
        if (idx_q == LW'(FCS_COUNT - 1)) begin
          st_d  = ST_GAP;
          idx_d = '0;
          gap_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_q == GW'(GAP_CYCLES - 1)) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // ---------------------------------------------------------------
  // Registers
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      gap_q  <= '0;
      txd_q  <= 8'h00;
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      gap_q  <= gap_d;
      txd_q  <= txd_d;
      en_q   <= en_d;
      done_q <= done_d;
    end
  end

  // Request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      da_q  <= '0;
      sa_q  <= '0;
      len_q <= '0;
    end else if (accept) begin
      da_q  <= dst_mac;
      sa_q  <= src_mac;
      len_q <= pay_len;
    end
  end

  assign gmii_txd   = txd_q;
  assign gmii_tx_en = en_q;
  assign gmii_tx_er = 1'b0;
  assign done       = done_q;

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  // R2: no frame leaves before the arming sequence completes
  p_tx_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gmii_tx_en) |-> armed);

  // R3: every frame opens with a preamble byte
  p_first_byte_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gmii_tx_en) |-> (gmii_txd == PRE_BYTE));

  // R7: quiet bus carries zero data
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gmii_tx_en |-> (gmii_txd == 8'h00));

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: nothing is sent while the gap is running
  p_gap_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |=> !gmii_tx_en);

  // R10: payload phase only runs with a legal captured length
  p_len_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAY) |-> ((len_q >= LW'(PAY_MIN)) && (len_q <= LW'(PAY_MAX))));

endmodule

// File: tb/sim_gmii_frame_tx.sv
module sim_gmii_frame_tx;

  localparam int CLK_PERIOD = 10;
  localparam int PAY_MIN    = 46;
  localparam int PAY_MAX    = 1500;
  localparam int GAP        = 200;
  localparam int LW         = $clog2(PAY_MAX + 1);
  localparam int AW         = $clog2(PAY_MAX);

  logic          clk;
  logic          rst_n;
  logic          cfg_busy;
  logic          start;
  logic [47:0]   dst_mac;
  logic [47:0]   src_mac;
  logic [LW-1:0] pay_len;
  logic          buf_we;
  logic [AW-1:0] buf_waddr;
  logic [7:0]    buf_wdata;
  logic          ready;
  logic          done;
  logic [7:0]    gmii_txd;
  logic          gmii_tx_en;
  logic          gmii_tx_er;

  gmii_frame_tx #(
    .PAY_MIN    (PAY_MIN),
    .PAY_MAX    (PAY_MAX),
    .GAP_CYCLES (GAP)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_busy   (cfg_busy),
    .start      (start),
    .dst_mac    (dst_mac),
    .src_mac    (src_mac),
    .pay_len    (pay_len),
    .buf_we     (buf_we),
    .buf_waddr  (buf_waddr),
    .buf_wdata  (buf_wdata),
    .ready      (ready),
    .done       (done),
    .gmii_txd   (gmii_txd),
    .gmii_tx_en (gmii_tx_en),
    .gmii_tx_er (gmii_tx_er)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  int checks   = 0;
  int fails    = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // ---------------------------------------------------------------
  // Reference model
  // ---------------------------------------------------------------
  logic [31:0] crc_tab [256];
  logic [7:0]  mbuf [PAY_MAX];
  logic [7:0]  q [$];
  string       tq [$];
  int          m_phase;
  int          m_mode;
  int          m_gap;
  logic [7:0]  exp_txd;
  logic        exp_en;
  logic        exp_ready;
  logic        exp_done;
  string       exp_tag;

  initial begin
    for (int n = 0; n < 256; n++) begin
      logic [31:0] c;
      c = 32'(n);
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      crc_tab[n] = c;
    end
  end

  task automatic push_byte(input logic [7:0] b, input string tag);
    q.push_back(b);
    tq.push_back(tag);
  endtask

  task automatic build_frame();
    logic [31:0] c;
    logic [7:0]  hb [14];
    for (int i = 0; i < 7; i++) push_byte(8'h55, "R3");
    push_byte(8'hD5, "R3");
    for (int i = 0; i < 6; i++) hb[i]     = dst_mac[47 - 8*i -: 8];
    for (int i = 0; i < 6; i++) hb[6 + i] = src_mac[47 - 8*i -: 8];
    hb[12] = 8'(16'(pay_len) >> 8);
    hb[13] = 8'(pay_len);
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 14; i++) begin
      push_byte(hb[i], "R4");
      c = crc_tab[(c[7:0] ^ hb[i])] ^ (c >> 8);
    end
    for (int i = 0; i < int'(pay_len); i++) begin
      push_byte(mbuf[i], "R5");
      c = crc_tab[(c[7:0] ^ mbuf[i])] ^ (c >> 8);
    end
    c = ~c;
    for (int i = 0; i < 4; i++) push_byte(c[8*i +: 8], "R6");
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase   = 0;
      m_mode    = 0;
      m_gap     = 0;
      q.delete();
      tq.delete();
      exp_txd   = 8'h00;
      exp_en    = 1'b0;
      exp_ready = 1'b0;
      exp_done  = 1'b0;
      exp_tag   = "R1";
    end else begin
      bit pre_ready;
      pre_ready = (m_phase == 3) && (m_mode == 0);
      exp_done  = 1'b0;
      if (m_mode == 1) begin
        exp_en  = 1'b1;
        exp_txd = q.pop_front();
        exp_tag = tq.pop_front();
        if (q.size() == 0) begin
          m_mode = 2;
          m_gap  = 0;
        end
      end else if (m_mode == 2) begin
        exp_en  = 1'b0;
        exp_txd = 8'h00;
        exp_tag = "R8";
        if (m_gap == GAP - 1) begin
          m_mode   = 0;
          exp_done = 1'b1;
        end else begin
          m_gap++;
        end
      end else begin
        exp_en  = 1'b0;
        exp_txd = 8'h00;
        exp_tag = "R7";
        if (pre_ready && start && int'(pay_len) >= PAY_MIN && int'(pay_len) <= PAY_MAX) begin
          build_frame();
          m_mode = 1;
        end
      end
      case (m_phase)
        0: if (!cfg_busy) m_phase = 1;
        1: if (cfg_busy)  m_phase = 2;
        2: if (!cfg_busy) m_phase = 3;
        default: m_phase = 3;
      endcase
      if (buf_we && int'(buf_waddr) < PAY_MAX) mbuf[buf_waddr] = buf_wdata;
      exp_ready = (m_phase == 3) && (m_mode == 0);
    end
  end

  // ---------------------------------------------------------------
  // Per-cycle comparison, away from the active edge
  // ---------------------------------------------------------------
  int frames   = 0;
  bit en_prev  = 1'b0;
  int low_run  = 0;
  int last_gap = -1;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(gmii_txd == exp_txd, exp_tag, "txd", gmii_txd, exp_txd);
      chk(gmii_tx_en == exp_en, "R7", "tx_en", gmii_tx_en, exp_en);
      chk(gmii_tx_er == 1'b0, "R7", "tx_er", gmii_tx_er, 0);
      chk(ready == exp_ready, "R2", "ready", ready, exp_ready);
      chk(done == exp_done, "R8", "done", done, exp_done);
      if (gmii_tx_en) begin
        if (!en_prev) begin
          frames++;
          last_gap = low_run;
        end
        low_run = 0;
      end else begin
        low_run++;
      end
      en_prev = gmii_tx_en;
    end
  end

  // ---------------------------------------------------------------
  // Stimulus helpers
  // ---------------------------------------------------------------
  task automatic fill_buf(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      buf_we    = 1'b1;
      buf_waddr = AW'(i);
      buf_wdata = 8'((seed + i * 7) ^ (i >> 3));
    end
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic pulse_start(input logic [47:0] da, input logic [47:0] sa, input int len);
    @(negedge clk);
    dst_mac = da;
    src_mac = sa;
    pay_len = LW'(len);
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete");
      finish_run();
    end
  end

  // ---------------------------------------------------------------
  // Test sequence
  // ---------------------------------------------------------------
  initial begin
    int f0;
    rst_n     = 1'b0;
    cfg_busy  = 1'b1;
    start     = 1'b0;
    dst_mac   = '0;
    src_mac   = '0;
    pay_len   = '0;
    buf_we    = 1'b0;
    buf_waddr = '0;
    buf_wdata = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(gmii_txd == 8'h00, "R1", "txd in reset", gmii_txd, 0);
    chk(gmii_tx_en == 1'b0, "R1", "tx_en in reset", gmii_tx_en, 0);
    chk(gmii_tx_er == 1'b0, "R1", "tx_er in reset", gmii_tx_er, 0);
    chk(ready == 1'b0, "R1", "ready in reset", ready, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    rst_n = 1'b1;

    // R2: busy high from reset, request dropped
    repeat (6) @(negedge clk);
    fill_buf(46, 8'h10);
    pulse_start(48'h0A0B0C0D0E0F, 48'h112233445566, 46);
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R2", "ready before low", ready, 0);
    // first low seen
    cfg_busy = 1'b0;
    repeat (4) @(negedge clk);
    pulse_start(48'h0A0B0C0D0E0F, 48'h112233445566, 46);
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R2", "ready after first low", ready, 0);
    // high seen
    cfg_busy = 1'b1;
    repeat (4) @(negedge clk);
    pulse_start(48'h0A0B0C0D0E0F, 48'h112233445566, 46);
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R2", "ready after high", ready, 0);
    chk(frames == 0, "R2", "frames before arming", frames, 0);
    // final low arms the block
    cfg_busy = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1, "R2", "ready after arming", ready, 1);

    // R3 R4 R5 R6: minimum-length frame
    pulse_start(48'hFFEEDDCCBBAA, 48'h020406080A0C, PAY_MIN);
    wait_done();
    chk(frames == 1, "R3", "frame count", frames, 1);

    // R9 R11: mid-frame request and address change
    fill_buf(60, 8'h5A);
    f0 = fails;
    pulse_start(48'h8899AABBCCDD, 48'h13579BDF0246, 60);
    repeat (20) @(negedge clk);
    dst_mac = 48'h000000000001;
    src_mac = 48'h000000000002;
    pay_len = LW'(50);
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    repeat (100) @(negedge clk);
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    wait_done();
    chk(fails == f0, "R11", "frame unaffected by input change", fails - f0, 0);
    chk(frames == 2, "R9", "no extra frame from busy request", frames, 2);

    // R10: out-of-range lengths
    pulse_start(48'h1, 48'h2, PAY_MIN - 1);
    repeat (5) @(negedge clk);
    chk(frames == 2, "R10", "short length ignored", frames, 2);
    chk(ready == 1'b1, "R10", "ready after short length", ready, 1);
    pulse_start(48'h1, 48'h2, PAY_MAX + 1);
    repeat (5) @(negedge clk);
    chk(frames == 2, "R10", "long length ignored", frames, 2);
    chk(ready == 1'b1, "R10", "ready after long length", ready, 1);

    // R8: back-to-back frames with start held
    fill_buf(47, 8'hC3);
    @(negedge clk);
    dst_mac = 48'h665544332211;
    src_mac = 48'hABCDEF012345;
    pay_len = LW'(47);
    start   = 1'b1;
    while (frames < 4) @(negedge clk);
    start = 1'b0;
    chk(last_gap == GAP + 1, "R8", "back-to-back idle cycles", last_gap, GAP + 1);
    wait_done();

    // R5: maximum payload length
    fill_buf(PAY_MAX, 8'h77);
    pulse_start(48'h0123456789AB, 48'hBA9876543210, PAY_MAX);
    wait_done();
    chk(frames == 5, "R5", "maximum-length frame sent", frames, 5);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule